// File: doc/BRIEF.md
# Multi-format I/Q input word assembler

This block takes two's-complement I/Q samples from a 12-bit data bus that has no data clock of its own. A fast system clock oversamples the bus. A single framing strobe tells the block where each input word begins, and in one timing mode it also says which half of the pair a word belongs to. The block delivers each complete sample pair as a parallel 12-bit I value and a 12-bit Q value, marked by a one-cycle valid pulse.

Three word lengths are supported: full words of 12 bits, half words of 6 bits and quarter words of 3 bits. In the two shorter formats, consecutive pieces are packed into each 12-bit value. The number of system clocks per input word is given as a static configuration input. A phase counter runs from the last synchronised rising edge of the strobe, and each word is sampled at the middle of its window.

In burst timing, words alternate I then Q, beginning with I at the strobe's rising edge. In continuous timing, the strobe level marks I (high) or Q (low). Continuous timing is legal only with full words. An illegal configuration raises an error flag and freezes the output.

Top module: `iq_word_assembler`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid`, `cfg_err`, `out_i` and `out_q` are all zero.
- R2: With burst timing and full words (`cfg_fmt`=0, `cfg_cont`=0), the first word after a strobe rise is I and the next is Q, alternating from there. Each I/Q pair produces exactly one `out_valid` pulse lasting one cycle. `out_i` and `out_q` carry the pair from that pulse until the next one.
- R3: The strobe and the data bus each reach the sampling logic two clocks late. A word is captured at the input value of cycle floor(`cfg_cpw`/2) of its window. Cycle 0 is the first clock edge at which the strobe is seen high. Later words follow every `cfg_cpw` clocks.
- R4: In the half format (`cfg_fmt`=1), each word carries a 6-bit piece on `data_in[5:0]`, and `data_in[11:6]` is ignored. Four pieces form a pair in the order I upper, I lower, Q upper, Q lower.
- R5: In the quarter format (`cfg_fmt`=2), each word carries a 3-bit piece on `data_in[2:0]`, and `data_in[11:3]` is ignored. Eight pieces form a pair, most significant first: four pieces for I, then four for Q.
- R6: Every synchronised strobe rise restarts the word phase. The strobe may go low during a Q word, and a shortened Q word followed by a rise still yields correctly sampled pairs.
- R7: A strobe rise that comes before a pair is complete discards the pieces gathered so far, and no valid pulse is produced for them.
- R8: In continuous timing (`cfg_cont`=1, full words), a word sampled while the synchronised strobe is high is taken as I, and one sampled while it is low is taken as Q. A pair is emitted on a Q word that follows an I word. A Q word with no pending I is dropped.
- R9: A configuration is illegal when `cfg_fmt`=3, or when `cfg_cont`=1 with `cfg_fmt` other than 0. In an illegal configuration, `cfg_err` is high from the next cycle and `out_valid` stays low. `out_i` and `out_q` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Word length: 0 full, 1 half, 2 quarter, 3 illegal |
| cfg_cont | input | 1 | 1 selects continuous timing, 0 selects burst timing |
| cfg_cpw | input | 8 | System clocks per input word (at least 2) |
| strobe_in | input | 1 | Asynchronous framing strobe |
| data_in | input | 12 | Input data bus |
| out_i | output | 12 | Assembled I sample |
| out_q | output | 12 | Assembled Q sample |
| out_valid | output | 1 | One-cycle pulse when a new pair is available |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
The hardest case to reach is the resynchronisation, where a strobe rise lands at a phase that differs from where the free-running counter would have sampled. The stimulus creates this by shortening a Q word by two clocks before raising the strobe again, so the following words are sampled correctly only if the phase restarts. A second hard case is a rise that arrives while half-format pieces are still being gathered. The bench reaches it by dropping the strobe for one word after three pieces and then raising it, and checks that only the later pair appears. Centre sampling is checked by putting the correct data on the bus only in the three cycles around the middle of each window, with junk in every other cycle.

// File: rtl/iqa_pkg.sv
package iqa_pkg;
  typedef enum logic [1:0] {
    FMT_FULL    = 2'd0,
    FMT_HALF    = 2'd1,
    FMT_QUARTER = 2'd2,
    FMT_RSVD    = 2'd3
  } fmt_e;

  // last piece index within one I/Q pair for each format
  function automatic logic [2:0] last_piece(input fmt_e f);
    case (f)
      FMT_HALF:    last_piece = 3'd3;
      FMT_QUARTER: last_piece = 3'd7;
      default:     last_piece = 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/iqa_sync.sv
module iqa_sync #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_in,
  input  logic [DW-1:0] data_in,
  output logic          rise,
  output logic          level,
  output logic [DW-1:0] data_dly
);
  logic          s1_q, s2_q, s3_q;
  logic [DW-1:0] d1_q, d2_q;

  // strobe synchroniser plus edge stage; data delayed to the same depth
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
      d1_q <= '0;
      d2_q <= '0;
    end else begin
      s1_q <= strobe_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
      d1_q <= data_in;
      d2_q <= d1_q;
    end
  end

  assign rise     = s2_q & ~s3_q;
  assign level    = s2_q;
  assign data_dly = d2_q;
endmodule

// File: rtl/iqa_phase.sv
module iqa_phase #(
  parameter int CPW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CPW_W-1:0] cpw,
  input  logic             rise,
  output logic             take
);
  logic [CPW_W-1:0] ph_q, ph_d, eff;
  logic [CPW_W-1:0] wrap_at, centre;

  always_comb begin
    wrap_at = cpw - 1'b1;
    centre  = cpw >> 1;
    eff     = rise ? '0 : ph_q;
    ph_d    = (eff >= wrap_at) ? '0 : eff + 1'b1;
    take    = (eff == centre);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/iqa_packer.sv
module iqa_packer
  import iqa_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  fmt_e          fmt,
  input  logic          cont,
  input  logic          illegal,
  input  logic          take,
  input  logic          rise,
  input  logic          level,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q,
  output logic          out_valid
);
  localparam int AW   = 2 * DW;
  localparam int PW_H = DW / 2;
  localparam int PW_Q = DW / 4;

  logic [2:0]    idx_q, idx_d;
  logic [AW-1:0] acc_q, acc_d, shifted;
  logic [DW-1:0] oi_q, oi_d, oq_q, oq_d;
  logic          val_d, acc_en, out_en;
  logic          val_q;

  always_comb begin
    case (fmt)
      FMT_HALF:    shifted = {acc_q[AW-PW_H-1:0], data[PW_H-1:0]};
      FMT_QUARTER: shifted = {acc_q[AW-PW_Q-1:0], data[PW_Q-1:0]};
      default:     shifted = {acc_q[DW-1:0], data};
    endcase
  end

  always_comb begin
    idx_d  = idx_q;
    acc_d  = acc_q;
    oi_d   = oi_q;
    oq_d   = oq_q;
    val_d  = 1'b0;
    acc_en = 1'b0;
    out_en = 1'b0;
    if (illegal) begin
      idx_d = '0;
    end else if (take) begin
      if (cont) begin
        if (level) begin
          acc_d  = {{DW{1'b0}}, data};
          acc_en = 1'b1;
          idx_d  = 3'd1;
        end else if (idx_q == 3'd1) begin
          oi_d   = acc_q[DW-1:0];
          oq_d   = data;
          out_en = 1'b1;
          val_d  = 1'b1;
          idx_d  = '0;
        end
      end else begin
        acc_d  = shifted;
        acc_en = 1'b1;
        if (idx_q == last_piece(fmt)) begin
          oi_d   = shifted[AW-1:DW];
          oq_d   = shifted[DW-1:0];
          out_en = 1'b1;
          val_d  = 1'b1;
          idx_d  = '0;
        end else begin
          idx_d = idx_q + 3'd1;
        end
      end
    end else if (rise) begin
      idx_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      acc_q <= '0;
      oi_q  <= '0;
      oq_q  <= '0;
      val_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      val_q <= val_d;
      if (acc_en) acc_q <= acc_d;
      if (out_en) begin
        oi_q <= oi_d;
        oq_q <= oq_d;
      end
    end
  end

  assign out_i     = oi_q;
  assign out_q     = oq_q;
  assign out_valid = val_q;
endmodule

// File: rtl/iq_word_assembler.sv
module iq_word_assembler
  import iqa_pkg::*;
#(
  parameter int DW    = 12,
  parameter int CPW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_fmt,
  input  logic             cfg_cont,
  input  logic [CPW_W-1:0] cfg_cpw,
  input  logic             strobe_in,
  input  logic [DW-1:0]    data_in,
  output logic [DW-1:0]    out_i,
  output logic [DW-1:0]    out_q,
  output logic             out_valid,
  output logic             cfg_err
);
  fmt_e          fmt;
  logic          illegal;
  logic          rise_w, level_w, take_w;
  logic [DW-1:0] data_w;
  logic          err_q;

  assign fmt     = fmt_e'(cfg_fmt);
  assign illegal = (fmt == FMT_RSVD) | (cfg_cont & (fmt != FMT_FULL));

  iqa_sync #(.DW(DW)) sync_i (
    .clk(clk), .rst_n(rst_n), .strobe_in(strobe_in), .data_in(data_in),
    .rise(rise_w), .level(level_w), .data_dly(data_w)
  );

  iqa_phase #(.CPW_W(CPW_W)) phase_i (
    .clk(clk), .rst_n(rst_n), .cpw(cfg_cpw), .rise(rise_w), .take(take_w)
  );

  iqa_packer #(.DW(DW)) pack_i (
    .clk(clk), .rst_n(rst_n), .fmt(fmt), .cont(cfg_cont), .illegal(illegal),
    .take(take_w), .rise(rise_w), .level(level_w), .data(data_w),
    .out_i(out_i), .out_q(out_q), .out_valid(out_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= illegal;
  end

  assign cfg_err = err_q;
endmodule

// File: rtl/iqa_chk.sv
module iqa_chk #(
  parameter int DW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    cfg_fmt,
  input logic          cfg_cont,
  input logic          rise,
  input logic [DW-1:0] out_i,
  input logic [DW-1:0] out_q,
  input logic          out_valid,
  input logic          cfg_err
);
  logic bad_cfg;
  assign bad_cfg = (cfg_fmt == 2'd3) || (cfg_cont && (cfg_fmt != 2'd0));

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R9
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cfg |=> cfg_err);

  // R9
  no_valid_when_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cfg |=> !out_valid);

  // R2
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_i) && $stable(out_q)));

  // R7
  rise_no_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !out_valid);
endmodule

bind iq_word_assembler iqa_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_cont(cfg_cont),
  .rise(rise_w), .out_i(out_i), .out_q(out_q), .out_valid(out_valid),
  .cfg_err(cfg_err)
);

// File: tb/iq_word_assembler_tb_top.sv
module iq_word_assembler_tb_top;
  logic        clk;
  logic        rst_n;
  logic [1:0]  cfg_fmt;
  logic        cfg_cont;
  logic [7:0]  cfg_cpw;
  logic        strobe_in;
  logic [11:0] data_in;
  logic [11:0] out_i, out_q;
  logic        out_valid, cfg_err;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  iq_word_assembler dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_cont(cfg_cont),
    .cfg_cpw(cfg_cpw), .strobe_in(strobe_in), .data_in(data_in),
    .out_i(out_i), .out_q(out_q), .out_valid(out_valid), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference model
  bit   st0, st1, st2;
  int   dt0, dt1;
  int   m_ph, m_idx, m_acc;
  int   m_i, m_q;
  bit   m_valid, m_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st0 = 0; st1 = 0; st2 = 0; dt0 = 0; dt1 = 0;
      m_ph = 0; m_idx = 0; m_acc = 0; m_i = 0; m_q = 0;
      m_valid = 0; m_err = 0;
    end else begin
      bit rise, lvl, bad, take;
      int dat, eff, np, pw, cpw;
      cpw  = cfg_cpw;
      rise = st1 && !st2;
      lvl  = st1;
      dat  = dt1;
      bad  = (cfg_fmt == 3) || (cfg_cont && cfg_fmt != 0);
      eff  = rise ? 0 : m_ph;
      take = (eff == cpw / 2);
      m_ph = (eff >= cpw - 1) ? 0 : eff + 1;
      np   = (cfg_fmt == 1) ? 2 : (cfg_fmt == 2) ? 4 : 1;
      pw   = 12 / np;
      m_valid = 0;
      if (bad) m_idx = 0;
      else if (take) begin
        if (cfg_cont) begin
          if (lvl) begin m_acc = dat; m_idx = 1; end
          else if (m_idx == 1) begin
            m_i = m_acc; m_q = dat; m_valid = 1; m_idx = 0;
          end
        end else begin
          m_acc = ((m_acc << pw) | (dat & ((1 << pw) - 1))) & 24'hFFFFFF;
          if (m_idx == 2 * np - 1) begin
            m_i = (m_acc >> 12) & 12'hFFF; m_q = m_acc & 12'hFFF;
            m_valid = 1; m_idx = 0;
          end else m_idx++;
        end
      end else if (rise) m_idx = 0;
      m_err = bad;
      st2 = st1; st1 = st0; st0 = strobe_in;
      dt1 = dt0; dt0 = data_in;
    end
  end

  int obs_i[$], obs_q[$], exp_i[$], exp_q[$];

  always @(negedge clk) begin
    checks++;
    if (out_valid !== m_valid || cfg_err !== m_err ||
        out_i !== 12'(m_i) || out_q !== 12'(m_q)) begin
      errors++;
      $display("FAIL %s cycle: v/e/i/q actual %0b %0b %h %h expected %0b %0b %h %h",
               cur_req, out_valid, cfg_err, out_i, out_q, m_valid, m_err,
               12'(m_i), 12'(m_q));
    end
    if (rst_n && out_valid) begin
      obs_i.push_back(int'(out_i));
      obs_q.push_back(int'(out_q));
    end
  end

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic start(input int fmt, input bit cont, input int cpw, input string req);
    @(negedge clk);
    cur_req = req;
    rst_n = 0; strobe_in = 0; data_in = 0;
    cfg_fmt = 2'(fmt); cfg_cont = cont; cfg_cpw = 8'(cpw);
    repeat (2) @(negedge clk);
    rst_n = 1;
    obs_i.delete(); obs_q.delete(); exp_i.delete(); exp_q.delete();
  endtask

  task automatic word(input bit s, input logic [11:0] v, input int len);
    repeat (len) begin
      @(negedge clk);
      strobe_in = s; data_in = v;
    end
  endtask

  // correct value only around the window centre, junk elsewhere
  task automatic word_c(input bit s, input logic [11:0] v);
    int h;
    h = int'(cfg_cpw) / 2;
    for (int j = 0; j < int'(cfg_cpw); j++) begin
      @(negedge clk);
      strobe_in = s;
      data_in = (j >= h - 1 && j <= h + 1) ? v : (v ^ 12'hFFF);
    end
  endtask

  // one 12-bit value as pieces with junk in the unused upper bits
  task automatic send_val(input bit s, input logic [11:0] v);
    int np, pw;
    logic [11:0] mask, pc;
    np = (cfg_fmt == 1) ? 2 : (cfg_fmt == 2) ? 4 : 1;
    pw = 12 / np;
    mask = 12'((1 << pw) - 1);
    for (int p = 0; p < np; p++) begin
      pc = (v >> (pw * (np - 1 - p))) & mask;
      word(s, pc | (12'hB6D & ~mask), int'(cfg_cpw));
    end
  endtask

  task automatic push_exp(input logic [11:0] i, input logic [11:0] q);
    exp_i.push_back(int'(i)); exp_q.push_back(int'(q));
  endtask

  task automatic finish_scn(input string req);
    word(strobe_in, 12'h000, int'(cfg_cpw) + 4);
    check({req, " pair count"}, obs_i.size(), exp_i.size());
    for (int k = 0; k < exp_i.size() && k < obs_i.size(); k++) begin
      check({req, " I"}, obs_i[k], exp_i[k]);
      check({req, " Q"}, obs_q[k], exp_q[k]);
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; strobe_in = 0; data_in = 0;
    cfg_fmt = 0; cfg_cont = 0; cfg_cpw = 8;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 valid", int'(out_valid), 0);
    check("R1 err", int'(cfg_err), 0);
    check("R1 out_i", int'(out_i), 0);
    check("R1 out_q", int'(out_q), 0);

    // R2 full-word burst
    start(0, 0, 8, "R2");
    send_val(1, 12'h123); send_val(1, 12'hABC); push_exp(12'h123, 12'hABC);
    send_val(1, 12'h800); send_val(1, 12'h7FF); push_exp(12'h800, 12'h7FF);
    send_val(1, 12'hFFF); send_val(1, 12'h001); push_exp(12'hFFF, 12'h001);
    finish_scn("R2");

    // R3 centre sampling, odd clocks per word
    start(0, 0, 7, "R3");
    word_c(1, 12'h5A5); word_c(1, 12'h3C3); push_exp(12'h5A5, 12'h3C3);
    word_c(1, 12'h0F0); word_c(1, 12'hE1E); push_exp(12'h0F0, 12'hE1E);
    finish_scn("R3");

    // R4 half format
    start(1, 0, 6, "R4");
    send_val(1, 12'h9C3); send_val(1, 12'h4B7); push_exp(12'h9C3, 12'h4B7);
    send_val(1, 12'h03F); send_val(1, 12'hFC0); push_exp(12'h03F, 12'hFC0);
    finish_scn("R4");

    // R5 quarter format
    start(2, 0, 4, "R5");
    send_val(1, 12'h6D2); send_val(1, 12'hB19); push_exp(12'h6D2, 12'hB19);
    send_val(1, 12'h888); send_val(1, 12'h777); push_exp(12'h888, 12'h777);
    finish_scn("R5");

    // R6 alternate timing: low during Q, shortened Q, then resync
    start(0, 0, 10, "R6");
    word(1, 12'h111, 10); word(0, 12'h222, 10); push_exp(12'h111, 12'h222);
    word(1, 12'h333, 10); word(0, 12'h444, 8);  push_exp(12'h333, 12'h444);
    word(1, 12'h555, 10); word(0, 12'h666, 8);  push_exp(12'h555, 12'h666);
    word(1, 12'h777, 10); word(1, 12'h999, 10); push_exp(12'h777, 12'h999);
    finish_scn("R6");

    // R7 rise mid-pair discards partial pieces
    start(1, 0, 6, "R7");
    word(1, 12'h015, 6); word(1, 12'h02A, 6); word(0, 12'h03F, 6);
    send_val(1, 12'hA5F); send_val(1, 12'h1E4); push_exp(12'hA5F, 12'h1E4);
    finish_scn("R7");

    // R8 continuous timing, leading Q words dropped
    start(0, 1, 8, "R8");
    word(0, 12'hDEA, 8); word(0, 12'hBEE, 8);
    word(1, 12'h246, 8); word(0, 12'h8AC, 8); push_exp(12'h246, 12'h8AC);
    word(1, 12'h135, 8); word(0, 12'h79B, 8); push_exp(12'h135, 12'h79B);
    word(1, 12'hF00, 8); word(0, 12'h00F, 8); push_exp(12'hF00, 12'h00F);
    finish_scn("R8");

    // R9 illegal configurations hold the output
    start(0, 0, 8, "R9");
    send_val(1, 12'h3A7); send_val(1, 12'hC59); push_exp(12'h3A7, 12'hC59);
    word(1, 12'h000, 4);
    @(negedge clk); cfg_cont = 1; cfg_fmt = 1;
    word(1, 12'h111, 8); word(0, 12'h222, 8); word(1, 12'h333, 8); word(0, 12'h444, 8);
    check("R9 err cont+half", int'(cfg_err), 1);
    check("R9 hold I", int'(out_i), 12'h3A7);
    @(negedge clk); cfg_cont = 0; cfg_fmt = 3;
    word(0, 12'h555, 8); word(1, 12'h666, 8); word(1, 12'h777, 8); word(1, 12'h888, 8);
    check("R9 err fmt3", int'(cfg_err), 1);
    check("R9 hold Q", int'(out_q), 12'hC59);
    finish_scn("R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule